// File: doc/BRIEF.md
# Transactional Read/Write Signature Unit

This unit keeps the read-set and write-set signatures of one hardware thread that runs memory transactions. Each signature is a partitioned Bloom filter over physical block addresses (64-byte blocks, offset already removed). It has one sub-filter per hash function, and each sub-filter is a bit vector indexed by its own hash. Transactional loads and stores that touch shared pages set bits. Coherence requests arriving from other cores query the filters, and the unit reports whether the request conflicts with the running transaction and of which kind.

Each hash costs only a row of two-input XOR gates. Every index is the XOR of a cache-index field of the block address with a page-number field of the same width, and the fields never overlap. A second pair of filters, the summary pair, stands for the descheduled threads of the same process. Software loads it whole through its own port. Every query tests it in the same way as the active pair. Commit or abort empties the active pair in one cycle and leaves the summary pair untouched.

Top module: `sigu_top`

## Requirements
- R1: With the defaults (2 hashes, 256-entry sub-filters, 24-bit block address b) the index of sub-filter h is b[7:0] XOR b[8+8h +: 8], so sub-filter 0 uses b[15:8] and sub-filter 1 uses b[23:16] as page field.
- R2: A query hits a filter only when the bit selected in every sub-filter is set. Any address whose indices all equal those of an inserted address hits (aliasing is allowed). No inserted address is ever missed until the filter is cleared or reloaded.
- R3: An insert sets bits only when ins_valid, ins_in_tx and ins_shared are all 1. ins_write=1 selects the write filter and ins_write=0 the read filter. Otherwise neither active filter changes.
- R4: conflict_kind is 0 none, 1 RW, 2 WR, 3 WW. A remote store (qry_is_store=1) that hits the write set gives WW. Otherwise, if it hits the read set it gives RW. A remote load that hits the write set gives WR, and in every other case the result is none. The result and conflict (1 exactly when the kind is not 0) appear in the cycle after qry_valid. Both are 0 in every cycle that does not follow a query.
- R5: The read set and the write set used by R4 are the OR of the active filter and the matching summary filter.
- R6: sum_wr_valid overwrites the summary read filter (sum_wr_sel=0) or the summary write filter (sum_wr_sel=1) with sum_wr_data. Bit h*256+i of the data is entry i of sub-filter h. clr_active leaves the summary filters unchanged.
- R7: clr_active empties both active filters in one cycle. An insert in the same cycle is dropped.
- R8: A query sees the filter contents from before any insert, clear or summary load issued in the same cycle.
- R9: After reset all four filters are empty and conflict and conflict_kind are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ins_valid | input | 1 | Local access to record |
| ins_blk | input | 24 | Block address of the local access |
| ins_write | input | 1 | 1 store, 0 load |
| ins_in_tx | input | 1 | Thread is inside a transaction |
| ins_shared | input | 1 | Page-shared bit from the translation entry |
| qry_valid | input | 1 | Incoming coherence request to test |
| qry_blk | input | 24 | Block address of the request |
| qry_is_store | input | 1 | 1 exclusive (store) request, 0 shared (load) request |
| clr_active | input | 1 | Commit or abort: empty the active filters |
| sum_wr_valid | input | 1 | Load one summary filter |
| sum_wr_sel | input | 1 | 0 summary read, 1 summary write |
| sum_wr_data | input | 512 | New summary filter contents |
| conflict | output | 1 | Previous cycle's query conflicts |
| conflict_kind | output | 2 | Previous cycle's conflict type |

## Verification
The functions that can meet in one cycle are an update (insert, clear or summary load) and a query on the same address. The bench drives both on one clock edge. It expects the query to report from the old contents and a repeat query one cycle later to report from the new ones. It also drives a clear together with an insert and expects the insert to be lost. Beyond these directed cases, a randomized phase mixes updates and queries in shared cycles. A reference model in the scoreboard updates its state only after it has computed the query expectation.

// File: rtl/sigu_pkg.sv
package sigu_pkg;
  typedef enum logic [1:0] {
    CF_NONE = 2'd0,
    CF_RW   = 2'd1,
    CF_WR   = 2'd2,
    CF_WW   = 2'd3
  } conf_e;
endpackage

// File: rtl/sigu_hash.sv
// One low-cost hash: XOR of a cache-index field and a page-number field.
module sigu_hash #(
  parameter int IDX_W = 8
) (
  input  logic [IDX_W-1:0] cix_fld,
  input  logic [IDX_W-1:0] ppn_fld,
  output logic [IDX_W-1:0] idx
);
  assign idx = cix_fld ^ ppn_fld;
endmodule

// File: rtl/sigu_filter.sv
// One signature: NUM_HASH sub-filters of 2**IDX_W bits each.
module sigu_filter #(
  parameter int NUM_HASH = 2,
  parameter int IDX_W    = 8,
  parameter int SIG_W    = NUM_HASH * (1 << IDX_W)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr_i,
  input  logic                      set_i,
  input  logic [NUM_HASH*IDX_W-1:0] set_idx_i,
  input  logic                      load_i,
  input  logic [SIG_W-1:0]          load_data_i,
  input  logic [NUM_HASH*IDX_W-1:0] tst_idx_i,
  output logic                      hit_o,
  output logic [SIG_W-1:0]          bits_o
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [SIG_W-1:0]    bits_q;
  logic [SIG_W-1:0]    bits_d;
  logic                upd_en;
  logic [NUM_HASH-1:0] sub_hit;

  always_comb begin
    bits_d = bits_q;
    if (load_i) begin
      bits_d = load_data_i;
    end else if (clr_i) begin
      bits_d = '0;
    end else if (set_i) begin
      for (int h = 0; h < NUM_HASH; h++) begin
        bits_d[h*ENTRIES + int'(set_idx_i[h*IDX_W +: IDX_W])] = 1'b1;
      end
    end
  end

  assign upd_en = load_i | clr_i | set_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
    end else if (upd_en) begin
      bits_q <= bits_d;
    end
  end

  for (genvar h = 0; h < NUM_HASH; h++) begin : g_sub
    assign sub_hit[h] = bits_q[h*ENTRIES + int'(tst_idx_i[h*IDX_W +: IDX_W])];
  end

  assign hit_o  = &sub_hit;
  assign bits_o = bits_q;
endmodule

// File: rtl/sigu_classify.sv
// Maps read/write hits and request type to a conflict type.
module sigu_classify
  import sigu_pkg::*;
(
  input  logic  rd_hit,
  input  logic  wr_hit,
  input  logic  is_store,
  output conf_e kind
);
  always_comb begin
    kind = CF_NONE;
    if (is_store) begin
      if (wr_hit)      kind = CF_WW;
      else if (rd_hit) kind = CF_RW;
    end else if (wr_hit) begin
      kind = CF_WR;
    end
  end
endmodule

// File: rtl/sigu_top.sv
module sigu_top
  import sigu_pkg::*;
#(
  parameter int NUM_HASH = 2,
  parameter int IDX_W    = 8,
  parameter int BLK_W    = (NUM_HASH + 1) * IDX_W,
  parameter int SIG_W    = NUM_HASH * (1 << IDX_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_valid,
  input  logic [BLK_W-1:0] ins_blk,
  input  logic             ins_write,
  input  logic             ins_in_tx,
  input  logic             ins_shared,
  input  logic             qry_valid,
  input  logic [BLK_W-1:0] qry_blk,
  input  logic             qry_is_store,
  input  logic             clr_active,
  input  logic             sum_wr_valid,
  input  logic             sum_wr_sel,
  input  logic [SIG_W-1:0] sum_wr_data,
  output logic             conflict,
  output logic [1:0]       conflict_kind
);
  localparam int HIDX_W = NUM_HASH * IDX_W;

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  // hashing of both address ports
  logic [HIDX_W-1:0] ins_idx;
  logic [HIDX_W-1:0] qry_idx;

  for (genvar h = 0; h < NUM_HASH; h++) begin : g_hash
    sigu_hash #(.IDX_W(IDX_W)) i_hash_ins (
      .cix_fld (ins_blk[0 +: IDX_W]),
      .ppn_fld (ins_blk[(h+1)*IDX_W +: IDX_W]),
      .idx     (ins_idx[h*IDX_W +: IDX_W])
    );
    sigu_hash #(.IDX_W(IDX_W)) i_hash_qry (
      .cix_fld (qry_blk[0 +: IDX_W]),
      .ppn_fld (qry_blk[(h+1)*IDX_W +: IDX_W]),
      .idx     (qry_idx[h*IDX_W +: IDX_W])
    );
  end

  // insert gating
  logic ins_ok;
  assign ins_ok = ins_valid & ins_in_tx & ins_shared;

  logic             act_rd_hit, act_wr_hit, sum_rd_hit, sum_wr_hit;
  logic [SIG_W-1:0] act_rd_bits, act_wr_bits, sum_rd_bits, sum_wr_bits;

  sigu_filter #(.NUM_HASH(NUM_HASH), .IDX_W(IDX_W), .SIG_W(SIG_W)) i_act_rd (
    .clk(clk), .rst_n(rst_int_n), .clr_i(clr_active), .set_i(ins_ok & ~ins_write),
    .set_idx_i(ins_idx), .load_i(1'b0), .load_data_i('0), .tst_idx_i(qry_idx),
    .hit_o(act_rd_hit), .bits_o(act_rd_bits)
  );

  sigu_filter #(.NUM_HASH(NUM_HASH), .IDX_W(IDX_W), .SIG_W(SIG_W)) i_act_wr (
    .clk(clk), .rst_n(rst_int_n), .clr_i(clr_active), .set_i(ins_ok & ins_write),
    .set_idx_i(ins_idx), .load_i(1'b0), .load_data_i('0), .tst_idx_i(qry_idx),
    .hit_o(act_wr_hit), .bits_o(act_wr_bits)
  );

  sigu_filter #(.NUM_HASH(NUM_HASH), .IDX_W(IDX_W), .SIG_W(SIG_W)) i_sum_rd (
    .clk(clk), .rst_n(rst_int_n), .clr_i(1'b0), .set_i(1'b0),
    .set_idx_i('0), .load_i(sum_wr_valid & ~sum_wr_sel), .load_data_i(sum_wr_data),
    .tst_idx_i(qry_idx), .hit_o(sum_rd_hit), .bits_o(sum_rd_bits)
  );

  sigu_filter #(.NUM_HASH(NUM_HASH), .IDX_W(IDX_W), .SIG_W(SIG_W)) i_sum_wr (
    .clk(clk), .rst_n(rst_int_n), .clr_i(1'b0), .set_i(1'b0),
    .set_idx_i('0), .load_i(sum_wr_valid & sum_wr_sel), .load_data_i(sum_wr_data),
    .tst_idx_i(qry_idx), .hit_o(sum_wr_hit), .bits_o(sum_wr_bits)
  );

  conf_e cls;
  sigu_classify i_cls (
    .rd_hit   (act_rd_hit | sum_rd_hit),
    .wr_hit   (act_wr_hit | sum_wr_hit),
    .is_store (qry_is_store),
    .kind     (cls)
  );

  // result registers
  logic       conf_d, conf_q;
  logic [1:0] kind_d, kind_q;

  always_comb begin
    conf_d = 1'b0;
    kind_d = CF_NONE;
    if (qry_valid) begin
      conf_d = (cls != CF_NONE);
      kind_d = cls;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      conf_q <= 1'b0;
      kind_q <= CF_NONE;
    end else begin
      conf_q <= conf_d;
      kind_q <= kind_d;
    end
  end

  assign conflict      = conf_q;
  assign conflict_kind = kind_q;
endmodule

// File: rtl/sigu_checker.sv
module sigu_checker #(
  parameter int SIG_W = 512
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ins_valid,
  input logic             ins_in_tx,
  input logic             ins_shared,
  input logic             qry_valid,
  input logic             qry_is_store,
  input logic             clr_active,
  input logic             sum_wr_valid,
  input logic             conflict,
  input logic [1:0]       conflict_kind,
  input logic [SIG_W-1:0] act_rd,
  input logic [SIG_W-1:0] act_wr,
  input logic [SIG_W-1:0] sum_rd,
  input logic [SIG_W-1:0] sum_wr
);
  // R4: no result without a query the cycle before
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !qry_valid |=> (!conflict && conflict_kind == 2'd0));

  // R4: a remote load can only give none or WR
  p_load_kind_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (qry_valid && !qry_is_store) |=> (conflict_kind == 2'd0 || conflict_kind == 2'd2));

  // R3: without a qualified insert or clear the active filters hold
  p_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!(ins_valid && ins_in_tx && ins_shared) && !clr_active) |=>
      ($stable(act_rd) && $stable(act_wr)));

  // R2: without clear no bit is ever lost (no false negatives)
  p_keep_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_active |=> (((act_rd & $past(act_rd)) == $past(act_rd)) &&
                     ((act_wr & $past(act_wr)) == $past(act_wr))));

  // R7: clear empties both active filters
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_active |=> (act_rd == '0 && act_wr == '0));

  // R6: summary filters change only through their load port
  p_sum_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sum_wr_valid |=> ($stable(sum_rd) && $stable(sum_wr)));
endmodule

bind sigu_top sigu_checker #(.SIG_W(SIG_W)) i_sigu_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .ins_valid     (ins_valid),
  .ins_in_tx     (ins_in_tx),
  .ins_shared    (ins_shared),
  .qry_valid     (qry_valid),
  .qry_is_store  (qry_is_store),
  .clr_active    (clr_active),
  .sum_wr_valid  (sum_wr_valid),
  .conflict      (conflict),
  .conflict_kind (conflict_kind),
  .act_rd        (act_rd_bits),
  .act_wr        (act_wr_bits),
  .sum_rd        (sum_rd_bits),
  .sum_wr        (sum_wr_bits)
);

// File: tb/test_sigu_top.sv
`timescale 1ns/1ps
module test_sigu_top;
  localparam int BW = 24;
  localparam int SW = 512;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ins_valid = 0, ins_write = 0, ins_in_tx = 0, ins_shared = 0;
  logic [BW-1:0] ins_blk = '0;
  logic          qry_valid = 0, qry_is_store = 0;
  logic [BW-1:0] qry_blk = '0;
  logic          clr_active = 0, sum_wr_valid = 0, sum_wr_sel = 0;
  logic [SW-1:0] sum_wr_data = '0;
  logic          conflict;
  logic [1:0]    conflict_kind;

  always #5 clk = ~clk;

  sigu_top i_sigu_top (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(ins_valid), .ins_blk(ins_blk), .ins_write(ins_write),
    .ins_in_tx(ins_in_tx), .ins_shared(ins_shared),
    .qry_valid(qry_valid), .qry_blk(qry_blk), .qry_is_store(qry_is_store),
    .clr_active(clr_active),
    .sum_wr_valid(sum_wr_valid), .sum_wr_sel(sum_wr_sel), .sum_wr_data(sum_wr_data),
    .conflict(conflict), .conflict_kind(conflict_kind)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit rst_done = 0;
  bit finished = 0;

  // reference model, bit h*256+i = entry i of sub-filter h (R6 layout)
  logic [SW-1:0] m_rd = '0, m_wr = '0, m_sr = '0, m_sw = '0;

  // scoreboard
  logic [1:0] exp_q[$];
  string      tag_q[$];
  logic       q_seen = 1'b0;

  // R1: index of sub-filter h
  function automatic int bidx(input logic [BW-1:0] b, input int h);
    return h * 256 + int'(b[7:0] ^ b[8 + 8*h +: 8]);
  endfunction

  function automatic bit in_sig(input logic [SW-1:0] s, input logic [BW-1:0] b);
    return s[bidx(b, 0)] && s[bidx(b, 1)];
  endfunction

  function automatic logic [SW-1:0] with_blk(input logic [SW-1:0] s, input logic [BW-1:0] b);
    logic [SW-1:0] r = s;
    r[bidx(b, 0)] = 1'b1;
    r[bidx(b, 1)] = 1'b1;
    return r;
  endfunction

  // R4/R5 expectation
  function automatic logic [1:0] model_kind(input logic [BW-1:0] b, input bit st);
    bit rh = in_sig(m_rd, b) || in_sig(m_sr, b);
    bit wh = in_sig(m_wr, b) || in_sig(m_sw, b);
    if (st) return wh ? 2'd3 : (rh ? 2'd1 : 2'd0);
    return wh ? 2'd2 : 2'd0;
  endfunction

  // one cycle of stimulus; called at a falling edge
  task automatic drive(input bit iv, input logic [BW-1:0] ia, input bit iw, input bit itx,
                       input bit ish, input bit qv, input logic [BW-1:0] qa, input bit qs,
                       input bit clr, input bit sv, input bit ssel,
                       input logic [SW-1:0] sdata, input int want, input string tag);
    ins_valid = iv; ins_blk = ia; ins_write = iw; ins_in_tx = itx; ins_shared = ish;
    qry_valid = qv; qry_blk = qa; qry_is_store = qs;
    clr_active = clr; sum_wr_valid = sv; sum_wr_sel = ssel; sum_wr_data = sdata;
    if (qv) begin
      exp_q.push_back(want < 0 ? model_kind(qa, qs) : 2'(want));
      tag_q.push_back(tag);
    end
    // model update after the query expectation (R8)
    if (sv) begin
      if (ssel) m_sw = sdata; else m_sr = sdata;
    end
    if (clr) begin
      m_rd = '0; m_wr = '0;
    end else if (iv && itx && ish) begin
      if (iw) m_wr = with_blk(m_wr, ia); else m_rd = with_blk(m_rd, ia);
    end
    @(posedge clk);
    @(negedge clk);
    ins_valid = 0; qry_valid = 0; clr_active = 0; sum_wr_valid = 0;
  endtask

  task automatic ins(input logic [BW-1:0] a, input bit w, input bit tx, input bit sh);
    drive(1, a, w, tx, sh, 0, '0, 0, 0, 0, 0, '0, -1, "");
  endtask

  task automatic qry(input logic [BW-1:0] a, input bit st, input int want, input string tag);
    drive(0, '0, 0, 0, 0, 1, a, st, 0, 0, 0, '0, want, tag);
  endtask

  task automatic sum_load(input bit sel, input logic [SW-1:0] data);
    drive(0, '0, 0, 0, 0, 0, '0, 0, 0, 1, sel, data, -1, "");
  endtask

  // monitor
  always @(posedge clk) q_seen <= qry_valid;

  always @(negedge clk) begin
    if (rst_done && !finished) begin
      if (q_seen) begin
        logic [1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_chk++;
        if (conflict_kind !== e || conflict !== (e != 2'd0)) begin
          n_bad++;
          $display("FAIL %s: kind=%0d flag=%0d expected kind=%0d flag=%0d",
                   t, conflict_kind, conflict, e, (e != 2'd0));
        end
      end else if (conflict !== 1'b0 || conflict_kind !== 2'd0) begin
        n_chk++;
        n_bad++;
        $display("FAIL R4 idle cycle: kind=%0d flag=%0d expected 0 0", conflict_kind, conflict);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  localparam logic [BW-1:0] A = 24'h123456;
  localparam logic [BW-1:0] B = 24'h0ABCDE;
  localparam logic [BW-1:0] C = 24'h330011;
  localparam logic [BW-1:0] D = B ^ 24'h010101;  // same indices as B
  localparam logic [BW-1:0] E = B ^ 24'h010000;  // sub-filter 0 matches B, 1 does not
  localparam logic [BW-1:0] F = 24'h445566;
  localparam logic [BW-1:0] G = 24'h778899;
  localparam logic [BW-1:0] H = 24'h5AA53C;

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rst_done = 1;
    // R9 reset state at the ports
    n_chk++;
    if (conflict !== 1'b0 || conflict_kind !== 2'd0) begin
      n_bad++;
      $display("FAIL R9 reset outputs: kind=%0d flag=%0d expected 0 0", conflict_kind, conflict);
    end
    qry(A, 1, 0, "R9 empty after reset");

    ins(A, 1, 1, 1);
    qry(A, 0, 2, "R4 WR remote load vs write set");
    qry(A, 1, 3, "R4 WW remote store vs write set");
    ins(B, 0, 1, 1);
    qry(B, 1, 1, "R4 RW remote store vs read set");
    qry(B, 0, 0, "R4 remote load vs read set only");
    ins(B, 1, 1, 1);
    qry(B, 1, 3, "R4 WW wins over RW");
    drive(0, '0, 0, 0, 0, 0, '0, 0, 1, 0, 0, '0, -1, "");
    ins(B, 0, 1, 1);
    qry(D, 1, 1, "R1 aliased indices hit");
    qry(E, 1, 0, "R2 all sub-filters needed");

    ins(C, 1, 1, 0);
    qry(C, 0, 0, "R3 private page not inserted");
    ins(C, 1, 0, 1);
    qry(C, 0, 0, "R3 outside transaction not inserted");

    drive(1, F, 1, 1, 1, 1, F, 1, 0, 0, 0, '0, 0, "R8 query before same-cycle insert");
    qry(F, 1, 3, "R3 insert visible next cycle");

    ins(A, 1, 1, 1);
    drive(0, '0, 0, 0, 0, 1, A, 0, 1, 0, 0, '0, 2, "R8 query before same-cycle clear");
    qry(A, 0, 0, "R7 write set cleared");
    qry(B, 1, 0, "R7 read set cleared");
    drive(1, G, 1, 1, 1, 0, '0, 0, 1, 0, 0, '0, -1, "");
    qry(G, 0, 0, "R7 clear beats insert");

    drive(0, '0, 0, 0, 0, 1, H, 0, 0, 1, 1, with_blk('0, H), 0,
          "R8 query before same-cycle summary load");
    qry(H, 0, 2, "R5 summary write set hit");
    sum_load(0, with_blk('0, G));
    qry(G, 1, 1, "R5 summary read set hit");
    drive(0, '0, 0, 0, 0, 0, '0, 0, 1, 0, 0, '0, -1, "");
    qry(H, 0, 2, "R6 summary survives clear");
    sum_load(1, '0);
    qry(H, 0, 0, "R6 summary overwritten");
    sum_load(0, '0);

    // randomized mix checked against the model (R2 R3 R4 R5 R8)
    begin
      logic [BW-1:0] pool[6];
      for (int i = 0; i < 6; i++) pool[i] = BW'($urandom);
      pool[5] = pool[0] ^ 24'h020202;
      for (int n = 0; n < 400; n++) begin
        int op = $urandom % 10;
        logic [BW-1:0] a = pool[$urandom % 6];
        logic [BW-1:0] q = pool[$urandom % 6];
        bit iv = (op < 6);
        bit qv = (op >= 3 && op < 9);
        bit cl = (op == 9) && ($urandom % 3 == 0);
        bit sv = (op == 9) && !cl;
        bit ss = $urandom % 2;
        logic [SW-1:0] sd = ($urandom % 3 == 0) ? '0 : with_blk(ss ? m_sw : m_sr, a);
        drive(iv, a, $urandom % 2, ($urandom % 4) != 0, ($urandom % 4) != 0,
              qv, q, $urandom % 2, cl, sv, ss, sd, -1, "R8 random mix");
      end
    end

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule